// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer

This block is a timer peripheral on a simple word-wide register bus. It has two 32-bit channels. Each channel counts down once per selected tick. It raises a sticky interrupt flag when it expires, and it can either park at zero or reload from a stored load value. The usual arrangement uses channel 0 as a one-shot event timer and channel 1 as a free-running timebase. Software reads the timebase as the bitwise inverse of its running count.

Each channel has three registers: a control register, a read-only running count and a writable load value. The control register and a global scratch register can each be reached at three addresses: plain write, bit-set and bit-clear. The set and clear addresses let software change single bits without a read-modify-write. Reads are combinational from the address: `bus_rdata` reflects `bus_addr` in the same cycle. Writes take effect at the clock edge where `bus_wen` is high. The bus has no stall, so there is no back-pressure. Every access completes in one cycle, and the remaining pins are plain control and status.

Top module: `dual_downtimer`

## Requirements
- R1: After reset, all control, running-count, load and global registers read 0, `irq` is 0, and address 0x120 reads 0x0200_0000 (major version 2 in bits [31:24]).
- R2: Address map (byte addresses): global register at 0x00. Channel n control at 0x20+n*0x40, running count at 0x30+n*0x40 (writes ignored), load value at 0x40+n*0x40. Any other address reads 0 and ignores writes.
- R3: Control word fields: bits [3:0] tick source, bit 6 reload, bit 7 immediate-load, bit 14 interrupt enable, bit 15 interrupt flag. All other bits read 0.
- R4: For the control and global registers, a write at base+0x0 replaces the value, a write at base+0x4 ORs the data in, and a write at base+0x8 clears the bits that are 1 in the data. Reads at all three addresses return the register.
- R5: Tick source 0xF ticks every clock. Source 0xB ticks in each cycle where `ext_tick` is high. Any other code holds the count.
- R6: On a tick, a nonzero running count decreases by exactly one, unless R8 or R9 applies.
- R7: A load-value write with immediate-load set also places the data in the running count, readable from the next cycle, and that cycle's tick is dropped. With immediate-load clear, the running count is untouched.
- R8: Without reload, a tick at count 1 takes the count to 0 and sets the flag. The count then stays at 0.
- R9: With reload, a tick at count 0 or 1 loads the count from the load value held before that cycle and sets the flag. A load of all-ones makes the inverted running count rise by one per tick.
- R10: The flag stays 1 until a clear-alias write with bit 15 set, or a plain write with bit 15 clear. If an expiry falls in the same cycle as the clear, the flag stays 1.
- R11: `irq` is 1 exactly when some channel has both its flag and its interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Slow tick enable, used by tick source 0xB |
| bus_addr | input | 9 | Byte address for read and write |
| bus_wen | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_addr`, `bus_wen` and `bus_wdata` are stable across each rising edge. They also assume that a clear request is judged only from the write seen at that edge, so a write must never be counted twice. The stimulus changes bus inputs and `ext_tick` only on falling edges, one access per cycle. It drives `ext_tick` as a free pattern that is independent of the bus. Clear writes are repeated on a short reload period, so that some of them land on the same edge as an expiry.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int WORD_W = 32;

  // Field positions inside the control word
  localparam int SRC_W      = 4;
  localparam int RELOAD_POS = 6;
  localparam int UPDATE_POS = 7;
  localparam int IEN_POS    = 14;
  localparam int FLAG_POS   = 15;

  localparam logic [SRC_W-1:0] SRC_EVERY = 4'hF;
  localparam logic [SRC_W-1:0] SRC_EXT   = 4'hB;

  // Address layout
  localparam int GLOBAL_OFS = 32'h000;
  localparam int CTRL_OFS   = 32'h020;
  localparam int RUN_OFS    = 32'h030;
  localparam int FIX_OFS    = 32'h040;
  localparam int CH_STRIDE  = 32'h040;
  localparam int SET_STEP   = 32'h4;
  localparam int CLR_STEP   = 32'h8;
  localparam int VER_OFS    = 32'h120;

  localparam logic [WORD_W-1:0] VERSION_WORD = 32'h0200_0000;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLEAR} reg_op_e;

  typedef struct packed {
    logic             flag;
    logic             ien;
    logic             update;
    logic             reload;
    logic [SRC_W-1:0] src;
  } chan_ctrl_t;

  function automatic logic [WORD_W-1:0] ctrl_to_word(input chan_ctrl_t c);
    logic [WORD_W-1:0] w;
    w             = '0;
    w[SRC_W-1:0]  = c.src;
    w[RELOAD_POS] = c.reload;
    w[UPDATE_POS] = c.update;
    w[IEN_POS]    = c.ien;
    w[FLAG_POS]   = c.flag;
    return w;
  endfunction

  function automatic chan_ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
    chan_ctrl_t c;
    c.src    = w[SRC_W-1:0];
    c.reload = w[RELOAD_POS];
    c.update = w[UPDATE_POS];
    c.ien    = w[IEN_POS];
    c.flag   = w[FLAG_POS];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] apply_word_op(input logic [WORD_W-1:0] cur,
                                                      input logic [WORD_W-1:0] wd,
                                                      input reg_op_e op);
    case (op)
      OP_WRITE: return wd;
      OP_SET:   return cur | wd;
      OP_CLEAR: return cur & ~wd;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/dtmr_alias_dec.sv
module dtmr_alias_dec #(
  parameter int AW = 9,
  parameter int BASE = 0
) (
  input  logic [AW-1:0]        addr,
  input  logic                 wen,
  output dtmr_pkg::reg_op_e    op,
  output logic                 hit
);
  import dtmr_pkg::*;

  localparam logic [AW-1:0] PLAIN_A = AW'(BASE);
  localparam logic [AW-1:0] SET_A   = AW'(BASE + SET_STEP);
  localparam logic [AW-1:0] CLR_A   = AW'(BASE + CLR_STEP);

  assign hit = (addr == PLAIN_A) || (addr == SET_A) || (addr == CLR_A);

  always_comb begin
    op = OP_NONE;
    if (wen) begin
      if (addr == PLAIN_A)    op = OP_WRITE;
      else if (addr == SET_A) op = OP_SET;
      else if (addr == CLR_A) op = OP_CLEAR;
    end
  end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
  parameter int CW = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ext_tick,
  input  dtmr_pkg::reg_op_e              ctrl_op,
  input  logic [dtmr_pkg::WORD_W-1:0]    wdata,
  input  logic                           fix_wr,
  output dtmr_pkg::chan_ctrl_t           ctrl,
  output logic [CW-1:0]                  run,
  output logic [CW-1:0]                  fixed,
  output logic                           irq_req
);
  import dtmr_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  chan_ctrl_t    ctrl_q, ctrl_d, wr_bits;
  logic [CW-1:0] run_q, run_d, fix_q;
  logic          tick, load_now, at_end, expire;

  assign tick     = (ctrl_q.src == SRC_EVERY) || ((ctrl_q.src == SRC_EXT) && ext_tick);
  assign load_now = fix_wr && ctrl_q.update;
  assign at_end   = ctrl_q.reload ? (run_q <= ONE) : (run_q == ONE);
  assign expire   = tick && at_end && !load_now;

  always_comb begin
    wr_bits = word_to_ctrl(wdata);
    case (ctrl_op)
      OP_WRITE: ctrl_d = wr_bits;
      OP_SET:   ctrl_d = chan_ctrl_t'(ctrl_q | wr_bits);
      OP_CLEAR: ctrl_d = chan_ctrl_t'(ctrl_q & ~wr_bits);
      default:  ctrl_d = ctrl_q;
    endcase
    // expiry outranks a same-cycle bus clear
    if (expire) ctrl_d.flag = 1'b1;
  end

  always_comb begin
    if (load_now)                     run_d = wdata[CW-1:0];
    else if (expire && ctrl_q.reload) run_d = fix_q;
    else if (tick && (run_q != '0))   run_d = run_q - ONE;
    else                              run_d = run_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      run_q  <= '0;
      fix_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      run_q  <= run_d;
      if (fix_wr) fix_q <= wdata[CW-1:0];
    end
  end

  assign ctrl    = ctrl_q;
  assign run     = run_q;
  assign fixed   = fix_q;
  assign irq_req = ctrl_q.flag && ctrl_q.ien;
endmodule

// File: rtl/dual_downtimer.sv
module dual_downtimer #(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ext_tick,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_wen,
  input  logic [dtmr_pkg::WORD_W-1:0]   bus_wdata,
  output logic [dtmr_pkg::WORD_W-1:0]   bus_rdata,
  output logic                          irq
);
  import dtmr_pkg::*;

  localparam logic [AW-1:0] VER_A = AW'(VER_OFS);

  chan_ctrl_t [NCH-1:0]   ctrl_all;
  logic [NCH-1:0][CW-1:0] run_all;
  logic [NCH-1:0][CW-1:0] fix_all;
  logic [NCH-1:0]         ctrl_hit, run_hit, fix_hit, irq_req;

  // Global scratch register with the same alias scheme
  reg_op_e           glob_op;
  logic              glob_hit;
  logic [WORD_W-1:0] glob_q;

  dtmr_alias_dec #(.AW(AW), .BASE(GLOBAL_OFS)) u_glob_dec (
    .addr(bus_addr), .wen(bus_wen), .op(glob_op), .hit(glob_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) glob_q <= '0;
    else        glob_q <= apply_word_op(glob_q, bus_wdata, glob_op);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [AW-1:0] RUN_A = AW'(RUN_OFS + ch * CH_STRIDE);
    localparam logic [AW-1:0] FIX_A = AW'(FIX_OFS + ch * CH_STRIDE);

    reg_op_e ctrl_op;

    dtmr_alias_dec #(.AW(AW), .BASE(CTRL_OFS + ch * CH_STRIDE)) u_ctrl_dec (
      .addr(bus_addr), .wen(bus_wen), .op(ctrl_op), .hit(ctrl_hit[ch])
    );

    assign run_hit[ch] = (bus_addr == RUN_A);
    assign fix_hit[ch] = (bus_addr == FIX_A);

    dtmr_channel #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_tick (ext_tick),
      .ctrl_op  (ctrl_op),
      .wdata    (bus_wdata),
      .fix_wr   (bus_wen && fix_hit[ch]),
      .ctrl     (ctrl_all[ch]),
      .run      (run_all[ch]),
      .fixed    (fix_all[ch]),
      .irq_req  (irq_req[ch])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (glob_hit)            bus_rdata = glob_q;
    if (bus_addr == VER_A)   bus_rdata = VERSION_WORD;
    for (int n = 0; n < NCH; n++) begin
      if (ctrl_hit[n]) bus_rdata = ctrl_to_word(ctrl_all[n]);
      if (run_hit[n])  bus_rdata = WORD_W'(run_all[n]);
      if (fix_hit[n])  bus_rdata = WORD_W'(fix_all[n]);
    end
  end

  assign irq = |irq_req;
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 9
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ext_tick,
  input logic [AW-1:0]                 bus_addr,
  input logic                          bus_wen,
  input logic [1:0]                    wd_hi,
  input dtmr_pkg::chan_ctrl_t [NCH-1:0] ctrl_vec,
  input logic [NCH-1:0][CW-1:0]        run_vec,
  input logic [NCH-1:0][CW-1:0]        fix_vec
);
  import dtmr_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] CA  = AW'(CTRL_OFS + n * CH_STRIDE);
    localparam logic [AW-1:0] CCA = AW'(CTRL_OFS + n * CH_STRIDE + CLR_STEP);
    localparam logic [AW-1:0] FA  = AW'(FIX_OFS + n * CH_STRIDE);

    logic tick, ldn, clr_req, ien_clr;
    assign tick    = (ctrl_vec[n].src == SRC_EVERY) || ((ctrl_vec[n].src == SRC_EXT) && ext_tick);
    assign ldn     = bus_wen && (bus_addr == FA) && ctrl_vec[n].update;
    assign clr_req = bus_wen && (((bus_addr == CA) && !wd_hi[1]) || ((bus_addr == CCA) && wd_hi[1]));
    assign ien_clr = bus_wen && (bus_addr == CCA) && wd_hi[0];

    // R5: a stopped source leaves the count alone
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_vec[n].src != SRC_EVERY) && (ctrl_vec[n].src != SRC_EXT) && !ldn) |=> $stable(run_vec[n]));

    // R6: the count only falls unless a load or reload happens
    a_r6_no_climb: assert property (@(posedge clk) disable iff (!rst_n)
      (!ldn && !(ctrl_vec[n].reload && (run_vec[n] <= ONE))) |=> (run_vec[n] <= $past(run_vec[n])));

    // R8: one-shot parks at zero
    a_r8_park_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_vec[n].reload && (run_vec[n] == '0) && !ldn) |=> (run_vec[n] == '0));

    // R8: expiry raises the flag
    a_r8_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (run_vec[n] == ONE) && !ldn) |=> ctrl_vec[n].flag);

    // R9: reload picks up the stored load value
    a_r9_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctrl_vec[n].reload && (run_vec[n] <= ONE) && !ldn) |=> (run_vec[n] == $past(fix_vec[n])));

    // R10: flag is sticky without a clear request
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_vec[n].flag && !clr_req) |=> ctrl_vec[n].flag);

    // R4: clear alias drops the enable bit
    a_r4_clear_alias_ien: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr |=> !ctrl_vec[n].ien);
  end
endmodule

bind dual_downtimer dtmr_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ext_tick (ext_tick),
  .bus_addr (bus_addr),
  .bus_wen  (bus_wen),
  .wd_hi    (bus_wdata[15:14]),
  .ctrl_vec (ctrl_all),
  .run_vec  (run_all),
  .fix_vec  (fix_all)
);

// File: tb/tb_dual_downtimer.sv
module tb_dual_downtimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  dual_downtimer dut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_ctrl [2];
  logic [31:0] m_run  [2];
  logic [31:0] m_fix  [2];
  logic [31:0] m_glob;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 2; n++) begin m_ctrl[n] = 0; m_run[n] = 0; m_fix[n] = 0; end
      m_glob = 0;
    end else begin
      for (int n = 0; n < 2; n++) begin
        int cb, fb;
        logic tk, ld, rl, ex;
        logic [31:0] nc;
        cb = 32'h20 + 64 * n;
        fb = 32'h40 + 64 * n;
        tk = (m_ctrl[n][3:0] == 4'hF) || (m_ctrl[n][3:0] == 4'hB && ext_tick);
        ld = bus_wen && (bus_addr == 9'(fb)) && m_ctrl[n][7];
        rl = m_ctrl[n][6];
        ex = tk && !ld && (rl ? (m_run[n] <= 1) : (m_run[n] == 1));
        nc = m_ctrl[n];
        if (bus_wen && bus_addr == 9'(cb))     nc = bus_wdata;
        if (bus_wen && bus_addr == 9'(cb + 4)) nc = nc | bus_wdata;
        if (bus_wen && bus_addr == 9'(cb + 8)) nc = nc & ~bus_wdata;
        nc = nc & 32'h0000_C0CF;
        if (ex) nc[15] = 1'b1;
        if (ld)                   m_run[n] = bus_wdata;
        else if (ex && rl)        m_run[n] = m_fix[n];
        else if (tk && m_run[n] != 0) m_run[n] = m_run[n] - 1;
        if (bus_wen && bus_addr == 9'(fb)) m_fix[n] = bus_wdata;
        m_ctrl[n] = nc;
      end
      if (bus_wen && bus_addr == 9'h000) m_glob = bus_wdata;
      if (bus_wen && bus_addr == 9'h004) m_glob = m_glob | bus_wdata;
      if (bus_wen && bus_addr == 9'h008) m_glob = m_glob & ~bus_wdata;
    end
  end

  function automatic logic [31:0] m_read(input logic [8:0] a);
    logic [31:0] r;
    r = 0;
    if (a == 9'h000 || a == 9'h004 || a == 9'h008) r = m_glob;
    if (a == 9'h120) r = 32'h0200_0000;
    for (int n = 0; n < 2; n++) begin
      if (a == 9'(32'h20 + 64*n) || a == 9'(32'h24 + 64*n) || a == 9'(32'h28 + 64*n)) r = m_ctrl[n];
      if (a == 9'(32'h30 + 64*n)) r = m_run[n];
      if (a == 9'(32'h40 + 64*n)) r = m_fix[n];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    if (a == 9'h120) return "R1";
    if (a == 9'h030 || a == 9'h070) return "R6";
    if (a == 9'h040 || a == 9'h080) return "R7";
    if (a[8:4] == 5'h02 || a[8:4] == 5'h06) return "R4";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R11", {31'b0, irq}, {31'b0, (m_ctrl[0][15] & m_ctrl[0][14]) | (m_ctrl[1][15] & m_ctrl[1][14])});
    end
  end

  task automatic cyc(input logic [8:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wen = w; bus_wdata = d;
  endtask

  task automatic rd(input logic [8:0] a);
    cyc(a, 1'b0, 32'h0);
  endtask

  task automatic rdchk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    rd(a);
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  localparam logic [8:0] C0 = 9'h020, RN0 = 9'h030, F0 = 9'h040;
  localparam logic [8:0] C1 = 9'h060, RN1 = 9'h070, F1 = 9'h080;

  initial begin
    logic [31:0] a, b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdchk("R1", 9'h120, 32'h0200_0000);
    rdchk("R1", C0, 32'h0);
    rdchk("R1", RN1, 32'h0);
    #1 chk("R1", {31'b0, irq}, 32'h0);
    // R2 global register and unmapped space
    cyc(9'h000, 1, 32'hA5A5_0000);
    cyc(9'h004, 1, 32'h0000_00FF);
    cyc(9'h008, 1, 32'h0500_000F);
    rdchk("R2", 9'h000, 32'hA0A5_00F0);
    cyc(9'h010, 1, 32'hFFFF_FFFF);
    rdchk("R2", 9'h010, 32'h0);
    rdchk("R2", C0, 32'h0);
    rdchk("R2", 9'h1FC, 32'h0);
    // R3 field layout, R11 irq, R10 clear
    cyc(C1, 1, 32'hFFFF_FF30);
    rdchk("R3", C1, 32'h0000_C000);
    #1 chk("R11", {31'b0, irq}, 32'h1);
    cyc(C1 + 9'h8, 1, 32'h0000_8000);
    rdchk("R10", C1, 32'h0000_4000);
    #1 chk("R11", {31'b0, irq}, 32'h0);
    cyc(C1, 1, 32'h0);
    // R4 aliases
    cyc(C0, 1, 32'h0);
    cyc(C0 + 9'h4, 1, 32'h0000_4080);
    rdchk("R4", C0 + 9'h8, 32'h0000_4080);
    cyc(C0 + 9'h8, 1, 32'h0000_0080);
    rdchk("R4", C0 + 9'h4, 32'h0000_4000);
    // R7 deferred and immediate load
    cyc(F0, 1, 32'd5);
    rdchk("R7", RN0, 32'd0);
    rdchk("R7", F0, 32'd5);
    cyc(C0 + 9'h4, 1, 32'h0000_0080);
    cyc(F0, 1, 32'd5);
    rdchk("R7", RN0, 32'd5);
    repeat (3) rd(RN0);
    rdchk("R5", RN0, 32'd5);
    // R6 / R8 one-shot countdown
    cyc(C0 + 9'h4, 1, 32'h0000_000F);
    repeat (2) rd(RN0);
    rdchk("R6", RN0, 32'd3);
    repeat (2) rd(RN0);
    rdchk("R8", RN0, 32'd0);
    #1 chk("R8", {31'b0, irq}, 32'h1);
    repeat (4) rd(RN0);
    rdchk("R8", RN0, 32'd0);
    cyc(C0 + 9'h8, 1, 32'h0000_8000);
    rdchk("R10", C0, 32'h0000_408F);
    #1 chk("R11", {31'b0, irq}, 32'h0);
    // R9 all-ones reload gives rising inverse
    cyc(C0, 1, 32'h0000_00CF);
    cyc(F0, 1, 32'hFFFF_FFFF);
    rd(RN0); #2 a = bus_rdata;
    rd(RN0); #2 b = bus_rdata;
    chk("R9", ~b, (~a) + 32'd1);
    chk("R9", a, 32'hFFFF_FFFF);
    cyc(C0, 1, 32'h0);
    // R5 / R9 slow tick source with reload on channel 1
    cyc(C1, 1, 32'h0000_40CB);
    cyc(F1, 1, 32'd3);
    for (int i = 0; i < 24; i++) begin
      rd(RN1);
      ext_tick = (i % 3 != 0);
    end
    rdchk("R9", C1, m_read(C1));
    #1 chk("R9", {31'b0, bus_rdata[15]}, 32'h1);
    ext_tick = 1'b0;
    rd(RN1); #2 a = bus_rdata;
    repeat (3) rd(RN1);
    #2 chk("R5", bus_rdata, a);
    // R10 clears racing expiries
    cyc(C1, 1, 32'h0000_40CF);
    cyc(F1, 1, 32'd2);
    for (int i = 0; i < 9; i++) cyc(C1 + 9'h8, 1, 32'h0000_8000);
    rd(C1);
    #2 chk("R10", bus_rdata, m_read(C1));
    repeat (4) rd(C1);
    #2 chk("R10", bus_rdata, m_read(C1));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule